// File: doc/BRIEF.md
# Burst Column Address Sequencer for a Synchronous Graphics DRAM

This block produces the column address that a synchronous graphics DRAM core uses on each clock of a read or write burst. A mode register, loaded by command, holds three things: the burst length code, the counting order (linear or interleaved), and a bit that limits writes to a single column. Each read, write or block-write command latches a starting column. From the next clock on, the block puts out one column per cycle until the burst ends.

A burst ends after its programmed number of beats. It also ends early on a precharge, or on a burst-stop when the length is full page. A fresh read, write or block-write abandons the running burst and restarts the sequence at once, so a column can be accessed at random on every clock. A data-valid window output covers the beats of the burst. For reads it also covers the CAS-latency-dependent tail after the last address.

Top module: `col_burst_seq`

## Requirements
- R1: After reset `col_valid` and `dq_valid` are low. The mode register resets to linear order, length code 000, and writes at the programmed length.
- R2: Length code `mode_val[2:0]` gives 1, 2, 4 or 8 beats for 000, 001, 010 and 011. Codes 100, 101 and 110 act as one beat. `col_valid` is high for exactly that many cycles, starting the cycle after the command edge.
- R3: With `mode_val[3]`=0 (linear order) and a length of 2, 4 or 8, beat k gives the start column with its low log2(length) bits replaced by (low bits + k) mod length. The upper bits stay fixed. Beat 0 appears in the cycle after the command edge.
- R4: With `mode_val[3]`=1 (interleaved order), the low log2(length) bits of beat k are the start's low bits XOR k. For lengths 1 and 2 this equals the linear order. For length 8, start low bits 000 give ascending columns and 111 give descending columns.
- R5: Length code 111 (full page) counts the whole column up by one per clock, with 255 followed by 0. It never ends by itself and always uses linear order.
- R6: A burst-stop (`cmd_stop`) during a full-page burst drops `col_valid` in the cycle after its edge. In any other length it is ignored and the burst completes all its beats.
- R7: When a read burst ends by a stop, a precharge or its last beat, `dq_valid` stays high 1 more cycle with `cas_lat`=0 (latency 2) and 2 more cycles with `cas_lat`=1 (latency 3). When a write burst ends, `dq_valid` falls together with `col_valid`.
- R8: With `mode_val[9]`=1, every write is a one-beat burst while reads keep the programmed length.
- R9: A block write (`cmd_bw`) forces column bits 2..0 to zero and lasts one beat, whatever the mode.
- R10: A read, write or block-write issued during a burst replaces it. The new start column appears in the next cycle, so one command per clock gives one arbitrary column per clock.
- R11: A precharge ends any burst in the next cycle. When several commands share an edge, block write beats write, write beats read, any of these beats precharge, and precharge beats stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_load | input | 1 | Load `mode_val` into the mode register |
| mode_val | input | 10 | [2:0] length code, [3] interleaved order, [9] single-beat writes |
| cmd_rd | input | 1 | Read command |
| cmd_wr | input | 1 | Write command |
| cmd_bw | input | 1 | Block-write command |
| cmd_stop | input | 1 | Burst-stop command |
| cmd_pre | input | 1 | Precharge command |
| col_in | input | COL_W | Starting column for rd/wr/bw |
| cas_lat | input | 1 | 0 selects latency 2, 1 selects latency 3 |
| col_out | output | COL_W | Column address for the current beat |
| col_valid | output | 1 | Burst active; `col_out` is meaningful |
| dq_valid | output | 1 | Data window, including the read tail |

## Verification
A corrupted beat counter or start register shows up in `col_out` on the next beat, because each beat's column is formed from those two registers alone. A wrong length mask shows up either as a beat at the wrong column or as `col_valid` falling a cycle early or late. Both faults are visible within at most eight cycles of the command. Faults in the full-page path or the stop path show up only over long runs, so the bench covers the 255 to 0 wrap and the exact cycle in which the window closes after a stop.

// File: rtl/colseq_pkg.sv
package colseq_pkg;

    // Field positions inside the mode word (decoded by colseq_mode).
    localparam int MODE_W      = 10;
    localparam int LEN_LSB     = 0;
    localparam int ORDER_BIT   = 3;
    localparam int WSINGLE_BIT = 9;

    // Length codes.
    localparam logic [2:0] LEN_1    = 3'b000;
    localparam logic [2:0] LEN_2    = 3'b001;
    localparam logic [2:0] LEN_4    = 3'b010;
    localparam logic [2:0] LEN_8    = 3'b011;
    localparam logic [2:0] LEN_PAGE = 3'b111;

    // Low column bits dropped by a block write.
    localparam int BLK_BITS = 3;

    typedef enum logic [2:0] {
        K_NONE,
        K_RD,
        K_WR,
        K_BW,
        K_PRE,
        K_STOP
    } cmd_kind_e;

endpackage

// File: rtl/colseq_mode.sv
module colseq_mode
    import colseq_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [MODE_W-1:0] val_i,
    output logic              ilv_o,
    output logic              wsingle_o,
    output logic              full_o,
    output logic [COL_W-1:0]  mask_o
);

    typedef struct packed {
        logic       ilv;
        logic       wsingle;
        logic [2:0] len;
    } mode_t;

    mode_t mode_d, mode_q;

    always_comb begin
        mode_d = mode_q;
        if (load_i) begin
            mode_d.ilv     = val_i[ORDER_BIT];
            mode_d.wsingle = val_i[WSINGLE_BIT];
            mode_d.len     = val_i[LEN_LSB +: 3];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= '0;
        else        mode_q <= mode_d;
    end

    // Length code to beat mask; undefined codes fall back to one beat.
    always_comb begin
        full_o = 1'b0;
        unique case (mode_q.len)
            LEN_2:    mask_o = COL_W'(1);
            LEN_4:    mask_o = COL_W'(3);
            LEN_8:    mask_o = COL_W'(7);
            LEN_PAGE: begin
                mask_o = '1;
                full_o = 1'b1;
            end
            default:  mask_o = '0;
        endcase
    end

    assign ilv_o     = mode_q.ilv;
    assign wsingle_o = mode_q.wsingle;

endmodule

// File: rtl/colseq_addr.sv
module colseq_addr #(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] start_i,
    input  logic [COL_W-1:0] beat_i,
    input  logic [COL_W-1:0] mask_i,
    input  logic             ilv_i,
    output logic [COL_W-1:0] col_o
);

    logic [COL_W-1:0] low;

    always_comb begin
        if (ilv_i) low = start_i ^ beat_i;
        else       low = start_i + beat_i;
        col_o = (start_i & ~mask_i) | (low & mask_i);
    end

endmodule

// File: rtl/colseq_dqwin.sv
module colseq_dqwin (
    input  logic clk,
    input  logic rst_n,
    input  logic active_i,
    input  logic end_rd_i,
    input  logic cl3_i,
    output logic dq_valid_o
);

    logic [1:0] tail_d, tail_q;

    always_comb begin
        tail_d = tail_q;
        if (end_rd_i)            tail_d = cl3_i ? 2'd2 : 2'd1;
        else if (tail_q != 2'd0) tail_d = tail_q - 2'd1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tail_q <= 2'd0;
        else        tail_q <= tail_d;
    end

    assign dq_valid_o = active_i | (tail_q != 2'd0);

endmodule

// File: rtl/col_burst_seq.sv
module col_burst_seq
    import colseq_pkg::*;
#(
    parameter int COL_W = 8   // must be at least BLK_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_load,
    input  logic [MODE_W-1:0] mode_val,
    input  logic              cmd_rd,
    input  logic              cmd_wr,
    input  logic              cmd_bw,
    input  logic              cmd_stop,
    input  logic              cmd_pre,
    input  logic [COL_W-1:0]  col_in,
    input  logic              cas_lat,
    output logic [COL_W-1:0]  col_out,
    output logic              col_valid,
    output logic              dq_valid
);

    localparam logic [COL_W-1:0] BLK_ALIGN = {{(COL_W-BLK_BITS){1'b1}}, {BLK_BITS{1'b0}}};

    typedef struct packed {
        logic             active;
        logic             is_rd;
        logic             ilv;
        logic             full;
        logic [COL_W-1:0] mask;
        logic [COL_W-1:0] start;
        logic [COL_W-1:0] beat;
        logic [COL_W-1:0] col;
    } bst_t;

    bst_t bst_d, bst_q;

    logic             m_ilv, m_wsingle, m_full;
    logic [COL_W-1:0] m_mask;
    logic [COL_W-1:0] beat_nx, col_nx;
    logic             end_rd;
    cmd_kind_e        kind;

    colseq_mode #(.COL_W(COL_W)) u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (mode_load),
        .val_i     (mode_val),
        .ilv_o     (m_ilv),
        .wsingle_o (m_wsingle),
        .full_o    (m_full),
        .mask_o    (m_mask)
    );

    assign beat_nx = bst_q.beat + COL_W'(1);

    colseq_addr #(.COL_W(COL_W)) u_addr (
        .start_i (bst_q.start),
        .beat_i  (beat_nx),
        .mask_i  (bst_q.mask),
        .ilv_i   (bst_q.ilv),
        .col_o   (col_nx)
    );

    // Command precedence.
    always_comb begin
        if      (cmd_bw)   kind = K_BW;
        else if (cmd_wr)   kind = K_WR;
        else if (cmd_rd)   kind = K_RD;
        else if (cmd_pre)  kind = K_PRE;
        else if (cmd_stop) kind = K_STOP;
        else               kind = K_NONE;
    end

    always_comb begin
        bst_d  = bst_q;
        end_rd = 1'b0;
        unique case (kind)
            K_BW: begin
                bst_d.active = 1'b1;
                bst_d.is_rd  = 1'b0;
                bst_d.ilv    = 1'b0;
                bst_d.full   = 1'b0;
                bst_d.mask   = '0;
                bst_d.start  = col_in & BLK_ALIGN;
                bst_d.beat   = '0;
                bst_d.col    = col_in & BLK_ALIGN;
            end
            K_WR, K_RD: begin
                bst_d.active = 1'b1;
                bst_d.is_rd  = (kind == K_RD);
                if (kind == K_WR && m_wsingle) begin
                    bst_d.full = 1'b0;
                    bst_d.mask = '0;
                end else begin
                    bst_d.full = m_full;
                    bst_d.mask = m_mask;
                end
                bst_d.ilv   = m_ilv & ~bst_d.full;
                bst_d.start = col_in;
                bst_d.beat  = '0;
                bst_d.col   = col_in;
            end
            K_PRE: begin
                if (bst_q.active) begin
                    bst_d.active = 1'b0;
                    end_rd       = bst_q.is_rd;
                end
            end
            K_STOP: begin
                if (bst_q.active && bst_q.full) begin
                    bst_d.active = 1'b0;
                    end_rd       = bst_q.is_rd;
                end else if (bst_q.active) begin
                    // Stop ignored: advance as on an idle cycle.
                    if (bst_q.beat == bst_q.mask) begin
                        bst_d.active = 1'b0;
                        end_rd       = bst_q.is_rd;
                    end else begin
                        bst_d.beat = beat_nx;
                        bst_d.col  = col_nx;
                    end
                end
            end
            default: begin
                if (bst_q.active) begin
                    if (!bst_q.full && bst_q.beat == bst_q.mask) begin
                        bst_d.active = 1'b0;
                        end_rd       = bst_q.is_rd;
                    end else begin
                        bst_d.beat = beat_nx;
                        bst_d.col  = col_nx;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bst_q <= '0;
        else        bst_q <= bst_d;
    end

    colseq_dqwin u_dqwin (
        .clk        (clk),
        .rst_n      (rst_n),
        .active_i   (bst_q.active),
        .end_rd_i   (end_rd),
        .cl3_i      (cas_lat),
        .dq_valid_o (dq_valid)
    );

    assign col_out   = bst_q.col;
    assign col_valid = bst_q.active;

endmodule

// File: rtl/colseq_chk.sv
module colseq_chk #(
    parameter int COL_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_rd,
    input logic             cmd_wr,
    input logic             cmd_bw,
    input logic             cmd_stop,
    input logic             cmd_pre,
    input logic [COL_W-1:0] col_out,
    input logic             col_valid,
    input logic             dq_valid,
    input logic             full_i
);

    logic any_cmd, start_cmd;
    assign start_cmd = cmd_rd | cmd_wr | cmd_bw;
    assign any_cmd   = start_cmd | cmd_pre | cmd_stop;

    a_r10_cmd_starts: assert property (@(posedge clk) disable iff (!rst_n)
        start_cmd |=> col_valid);

    a_r9_block_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_bw |=> (col_out[2:0] == 3'b000));

    a_r11_pre_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_pre && !start_cmd) |=> !col_valid);

    a_r6_stop_ends_page: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_stop && !cmd_pre && !start_cmd && col_valid && full_i) |=> !col_valid);

    a_r7_window_covers: assert property (@(posedge clk) disable iff (!rst_n)
        col_valid |-> dq_valid);

    a_r5_page_step: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid && $past(col_valid) && full_i && $past(full_i) && $past(!any_cmd))
        |-> (col_out == $past(col_out) + 1'b1));

endmodule

bind col_burst_seq colseq_chk #(.COL_W(COL_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_rd    (cmd_rd),
    .cmd_wr    (cmd_wr),
    .cmd_bw    (cmd_bw),
    .cmd_stop  (cmd_stop),
    .cmd_pre   (cmd_pre),
    .col_out   (col_out),
    .col_valid (col_valid),
    .dq_valid  (dq_valid),
    .full_i    (bst_q.full)
);

// File: tb/tb_col_burst_seq.sv
`timescale 1ns/1ps
module tb_col_burst_seq;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_load = 1'b0;
    logic [9:0] mode_val = '0;
    logic       cmd_rd = 1'b0, cmd_wr = 1'b0, cmd_bw = 1'b0, cmd_stop = 1'b0, cmd_pre = 1'b0;
    logic [7:0] col_in = '0;
    logic       cas_lat = 1'b0;
    logic [7:0] col_out;
    logic       col_valid, dq_valid;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    col_burst_seq #(.COL_W(8)) dut (
        .clk(clk), .rst_n(rst_n), .mode_load(mode_load), .mode_val(mode_val),
        .cmd_rd(cmd_rd), .cmd_wr(cmd_wr), .cmd_bw(cmd_bw), .cmd_stop(cmd_stop),
        .cmd_pre(cmd_pre), .col_in(col_in), .cas_lat(cas_lat),
        .col_out(col_out), .col_valid(col_valid), .dq_valid(dq_valid)
    );

    // {mode[3:0] = {order,len}, start, beats, beat0..beat7 from the top byte}
    localparam int NV = 11;
    localparam logic [79:0] VEC [0:NV-1] = '{
        {4'h2, 8'h17, 4'd4, 64'h17141516_00000000},  // R3 linear 4
        {4'hA, 8'h17, 4'd4, 64'h17161514_00000000},  // R4 interleaved 4
        {4'h3, 8'h23, 4'd8, 64'h23242526_27202122},  // R3 linear 8
        {4'hB, 8'h20, 4'd8, 64'h20212223_24252627},  // R4 ascending
        {4'hB, 8'h47, 4'd8, 64'h47464544_43424140},  // R4 descending
        {4'h9, 8'h31, 4'd2, 64'h31300000_00000000},  // R4 two-beat equals linear
        {4'h1, 8'h31, 4'd2, 64'h31300000_00000000},  // R2 two beats
        {4'h0, 8'h5A, 4'd1, 64'h5A000000_00000000},  // R2 one beat
        {4'h5, 8'h33, 4'd1, 64'h33000000_00000000},  // R2 undefined code
        {4'hB, 8'h65, 4'd8, 64'h65646766_61606362},  // R4 mid start
        {4'hE, 8'h21, 4'd1, 64'h21000000_00000000}   // R2 undefined code
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic load_mode(input logic [9:0] v);
        mode_val  = v;
        mode_load = 1'b1;
        step();
        mode_load = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        chk("R1 col_valid in reset", col_valid, 0);
        chk("R1 dq_valid in reset", dq_valid, 0);
        rst_n = 1'b1;
        step();
        chk("R1 idle after reset", {col_valid, dq_valid}, 0);

        // R1: default mode is one beat
        cmd_rd = 1'b1; col_in = 8'h44; step(); cmd_rd = 1'b0;
        chk("R1 default length beat0", {col_valid, col_out}, {1'b1, 8'h44});
        step();
        chk("R1 default length ends", col_valid, 0);
        idle(3);

        // Table walk: R2 R3 R4
        for (int v = 0; v < NV; v++) begin
            load_mode({6'b0, VEC[v][79:76]});
            cmd_rd = 1'b1; col_in = VEC[v][75:68]; step(); cmd_rd = 1'b0;
            for (int b = 0; b < int'(VEC[v][67:64]); b++) begin
                chk($sformatf("R2 R3 R4 vec %0d beat %0d", v, b),
                    {col_valid, col_out}, {1'b1, VEC[v][63-8*b -: 8]});
                step();
            end
            chk($sformatf("R2 vec %0d burst end", v), col_valid, 0);
            chk($sformatf("R7 vec %0d read tail", v), dq_valid, 1);
            idle(3);
        end

        // R5 full page with wrap, then R6 stop, R7 tail at latency 2
        load_mode(10'h007);
        cmd_rd = 1'b1; col_in = 8'hFD; step(); cmd_rd = 1'b0;
        for (int b = 0; b < 300; b++) begin
            chk("R5 full page column", {col_valid, col_out}, {1'b1, 8'(8'hFD + b)});
            if (b == 299) cmd_stop = 1'b1;
            step();
        end
        cmd_stop = 1'b0;
        chk("R6 stop ends full page", col_valid, 0);
        chk("R7 stop tail cl2 cycle1", dq_valid, 1);
        step();
        chk("R7 stop tail cl2 over", dq_valid, 0);

        // R7 latency 3
        cas_lat = 1'b1;
        cmd_rd = 1'b1; col_in = 8'h10; step(); cmd_rd = 1'b0;
        step();
        cmd_stop = 1'b1; step(); cmd_stop = 1'b0;
        chk("R6 stop ends full page cl3", col_valid, 0);
        chk("R7 stop tail cl3 cycle1", dq_valid, 1);
        step();
        chk("R7 stop tail cl3 cycle2", dq_valid, 1);
        step();
        chk("R7 stop tail cl3 over", dq_valid, 0);
        cas_lat = 1'b0;

        // R6 stop ignored at length 8
        load_mode(10'h003);
        cmd_rd = 1'b1; col_in = 8'h80; step(); cmd_rd = 1'b0;
        for (int b = 0; b < 8; b++) begin
            chk("R6 stop ignored at length 8", {col_valid, col_out}, {1'b1, 8'(8'h80 + b)});
            cmd_stop = (b == 1);
            step();
        end
        cmd_stop = 1'b0;
        chk("R6 length 8 ends normally", col_valid, 0);
        idle(3);

        // R8 single-beat writes, reads unaffected; R7 no write tail
        load_mode(10'h202);
        cmd_wr = 1'b1; col_in = 8'h40; step(); cmd_wr = 1'b0;
        chk("R8 write beat0", {col_valid, col_out}, {1'b1, 8'h40});
        step();
        chk("R8 write single beat", col_valid, 0);
        chk("R7 no tail after write", dq_valid, 0);
        idle(2);
        cmd_rd = 1'b1; col_in = 8'h40; step(); cmd_rd = 1'b0;
        for (int b = 0; b < 4; b++) begin
            chk("R8 read keeps length", {col_valid, col_out}, {1'b1, 8'(8'h40 + b)});
            step();
        end
        chk("R8 read ends after 4", col_valid, 0);
        idle(3);

        // R9 block write
        load_mode(10'h003);
        cmd_bw = 1'b1; col_in = 8'h2D; step(); cmd_bw = 1'b0;
        chk("R9 block write aligned", {col_valid, col_out}, {1'b1, 8'h28});
        step();
        chk("R9 block write single beat", col_valid, 0);
        idle(3);

        // R10 interrupt
        cmd_rd = 1'b1; col_in = 8'h10; step(); cmd_rd = 1'b0;
        chk("R10 first burst beat0", col_out, 8'h10);
        step();
        chk("R10 first burst beat1", col_out, 8'h11);
        cmd_rd = 1'b1; col_in = 8'h50; step(); cmd_rd = 1'b0;
        chk("R10 new burst starts", {col_valid, col_out}, {1'b1, 8'h50});
        step();
        chk("R10 new burst beat1", col_out, 8'h51);
        // R10 random column each clock
        cmd_rd = 1'b1; col_in = 8'h03; step();
        chk("R10 random 0", col_out, 8'h03);
        col_in = 8'h9C; step();
        chk("R10 random 1", col_out, 8'h9C);
        col_in = 8'hE1; step(); cmd_rd = 1'b0;
        chk("R10 random 2", col_out, 8'hE1);
        idle(10);

        // R11 precharge ends burst, read tail follows
        cmd_rd = 1'b1; col_in = 8'h60; step(); cmd_rd = 1'b0;
        step();
        cmd_pre = 1'b1; step(); cmd_pre = 1'b0;
        chk("R11 precharge ends burst", col_valid, 0);
        chk("R7 precharge read tail", dq_valid, 1);
        idle(3);

        // R11 precedence
        load_mode(10'h007);
        cmd_rd = 1'b1; col_in = 8'h00; step(); cmd_rd = 1'b0;
        cmd_pre = 1'b1; cmd_rd = 1'b1; col_in = 8'h70; step();
        cmd_pre = 1'b0; cmd_rd = 1'b0;
        chk("R11 read beats precharge", {col_valid, col_out}, {1'b1, 8'h70});
        cmd_rd = 1'b1; cmd_wr = 1'b1; cmd_bw = 1'b1; col_in = 8'h9F; step();
        cmd_rd = 1'b0; cmd_wr = 1'b0; cmd_bw = 1'b0;
        chk("R11 block write beats others", {col_valid, col_out}, {1'b1, 8'h98});
        step();
        chk("R11 block write one beat", col_valid, 0);
        cmd_rd = 1'b1; col_in = 8'h20; step(); cmd_rd = 1'b0;
        cmd_pre = 1'b1; cmd_stop = 1'b1; step();
        cmd_pre = 1'b0; cmd_stop = 1'b0;
        chk("R11 precharge with stop ends", col_valid, 0);
        idle(3);

        summary();
    end

endmodule